// File: doc/BRIEF.md
# Mode-Selectable Synchronous Clock Ratio Divider

This block turns one fast synchronous clock into a family of related output clock levels: a CPU-rate clock, a half-rate CPU clock, a mid-rate (66 MHz-class) clock, a PCI-rate clock, a slow interrupt-controller clock, a reference passthrough and a USB-rate passthrough. All divided outputs come from a single phase counter. Their rising edges therefore fall on a common edge of the fast clock, and no output is derived from another output by ripple.

A three-bit select `{sel_freq, sel_mode[1], sel_mode[0]}` chooses the ratio set. `sel_freq=1` selects the fast ratio set and `sel_freq=0` the slow one. The all-zero select floats every output. `{0,1,0}` is a bypass test mode: the phase counter steps on rising edges of the external test clock on `xtal_in`, so every output becomes a fixed power-of-two division of that test clock. Any change of the select restarts the counter, so no output ever shows a truncated pulse after a switch. The mid-rate output of the slow set needs a divide-by-three. It keeps a 50% duty cycle by ORing a rising-edge state with a copy of it retimed on the falling edge.

Top module: `sysclk_ratio_div`

## Requirements
- R1: While `rst_n` is low, every clock output, `core_oe` and `usb_oe` are 0.
- R2: The select `{sel_freq,sel_mode}` is sampled on every rising edge of `clk`. An edge that samples a value different from the previous sample restarts the phase. After that edge, `core_oe` equals (select != 3'b000), and for a non-zero select `cpu_clk`, `cpu_half_clk`, `mid_clk`, `pci_clk` and `apic_clk` are all 1 together.
- R3: With select 3'b000, `core_oe` and `usb_oe` are 0 and every clock output is 0.
- R4: With `sel_freq`=1 (any `sel_mode`), the outputs have these periods in `clk` cycles: `cpu_clk` 2, `cpu_half_clk` 4, `mid_clk` 4, `pci_clk` 8, `apic_clk` 16. Each output is high for the first half of its period, counted from the restart edge.
- R5: With `sel_freq`=0 and `sel_mode` 2'b01 or 2'b11, the periods are: `cpu_clk` 2, `cpu_half_clk` 4, `pci_clk` 6, `apic_clk` 12. Each output is high for the first half of its period, counted from the restart edge.
- R6: In the R5 modes, `mid_clk` has a period of 3 `clk` cycles. It rises on the restart-aligned rising edge and falls on the falling edge 1.5 cycles later, giving a 50% duty cycle.
- R7: With select 3'b010 (test), the phase advances one step on the rising edge after the first edge that samples `xtal_in` high following a low sample, and holds otherwise. The periods in steps are: `cpu_clk` and `usb_clk` 2, `cpu_half_clk` and `mid_clk` 4, `pci_clk` 8, `apic_clk` 16.
- R8: For every non-zero select, `ref_clk` equals `xtal_in` as sampled at the previous rising edge. For select 3'b000 it is 0.
- R9: With `sel_mode`=2'b01 (either `sel_freq`), `usb_oe` and `usb_clk` are 0. In the other non-zero, non-test selects, `usb_oe` is 1 and `usb_clk` equals `usb_in` as sampled at the previous rising edge.
- R10: Every rising edge of `pci_clk` lands while `cpu_clk` is high. Every rising edge of `apic_clk` lands while `pci_clk` and `cpu_half_clk` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synchronous source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_freq | input | 1 | Ratio-set select: 1 fast, 0 slow |
| sel_mode | input | 2 | Mode bits, together with `sel_freq` form the select |
| xtal_in | input | 1 | Reference level, also the test clock in bypass mode |
| usb_in | input | 1 | USB-rate clock level passed through in normal modes |
| cpu_clk | output | 1 | CPU-rate clock level |
| cpu_half_clk | output | 1 | Half CPU-rate clock level |
| mid_clk | output | 1 | Mid-rate clock level |
| pci_clk | output | 1 | PCI-rate clock level |
| apic_clk | output | 1 | Interrupt-controller clock level |
| ref_clk | output | 1 | Registered reference passthrough |
| usb_clk | output | 1 | USB-rate clock level |
| core_oe | output | 1 | Output enable for all outputs except `usb_clk` |
| usb_oe | output | 1 | Output enable for `usb_clk` |

## Verification
The enables, the divided levels, `ref_clk` and `usb_clk` all change one rising edge after the inputs that drive them are sampled. A select change is therefore visible just after the edge that samples it, with all divided outputs high. In test mode, a rising `xtal_in` shows up as a phase step only on the second edge after it is driven, because the input passes through two sampling stages before the edge is detected. The slow-set `mid_clk` also changes half a cycle after a rising edge. The bench therefore steps a model of its own once per rising edge and compares every output 0.5 ns after both the rising and the falling edge of `clk`. Inputs change only just after a falling edge.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

  localparam int unsigned LANES      = 5;
  localparam int unsigned PERIOD_MAX = 16;
  localparam int unsigned PHASE_W    = $clog2(PERIOD_MAX);

  localparam int unsigned L_CPU  = 0;
  localparam int unsigned L_HALF = 1;
  localparam int unsigned L_MID  = 2;
  localparam int unsigned L_PCI  = 3;
  localparam int unsigned L_APIC = 4;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_FAST = 2'd1,
    MD_SLOW = 2'd2,
    MD_TEST = 2'd3
  } ratio_mode_e;

  // select {freq, mode} -> ratio set
  function automatic ratio_mode_e decode_sel(input logic freq, input logic [1:0] msel);
    if ({freq, msel} == 3'b000)       return MD_OFF;
    else if (!freq && msel == 2'b10)  return MD_TEST;
    else if (freq)                    return MD_FAST;
    else                              return MD_SLOW;
  endfunction

  function automatic logic usb_allowed(input logic freq, input logic [1:0] msel);
    return ({freq, msel} != 3'b000) && (msel != 2'b01);
  endfunction

  // counter wrap length for a ratio set
  function automatic int unsigned cycle_len(input ratio_mode_e m);
    return (m == MD_SLOW) ? 12 : 16;
  endfunction

  // division factor of one lane in a ratio set
  function automatic int unsigned lane_div(input ratio_mode_e m, input int unsigned lane);
    case (lane)
      L_CPU:   return 2;
      L_HALF:  return 4;
      L_MID:   return (m == MD_SLOW) ? 3 : 4;
      L_PCI:   return (m == MD_SLOW) ? 6 : 8;
      default: return (m == MD_SLOW) ? 12 : 16;
    endcase
  endfunction

  // rising-edge level of a lane at a given phase; odd divide marks only the first step
  function automatic logic lane_level(input int unsigned ph, input int unsigned div);
    if (div == 3) return (ph % 3) == 0;
    return (ph % div) < (div / 2);
  endfunction

endpackage

// File: rtl/sysclk_div_sel.sv
module sysclk_div_sel
  import sysclk_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_freq,
  input  logic [1:0]  sel_mode,
  output ratio_mode_e mode_q,
  output ratio_mode_e mode_nxt,
  output logic        usb_on_q,
  output logic        usb_on_nxt,
  output logic        restart
);

  logic [2:0] sel_q;
  logic [2:0] sel_now;

  assign sel_now    = {sel_freq, sel_mode};
  assign restart    = (sel_now != sel_q);
  assign mode_nxt   = decode_sel(sel_freq, sel_mode);
  assign usb_on_nxt = usb_allowed(sel_freq, sel_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 3'b000;
      mode_q   <= MD_OFF;
      usb_on_q <= 1'b0;
    end else begin
      sel_q    <= sel_now;
      mode_q   <= mode_nxt;
      usb_on_q <= usb_on_nxt;
    end
  end

endmodule

// File: rtl/sysclk_div_phase.sv
module sysclk_div_phase
  import sysclk_div_pkg::*;
#(
  parameter int unsigned PH_W = PHASE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  ratio_mode_e     mode_q,
  input  logic            xtal_in,
  output logic [PH_W-1:0] phase_nxt,
  output logic            adv
);

  logic [PH_W-1:0] phase_q;
  logic            xtal_q, xtal_qq, xtal_rise, at_wrap;

  assign xtal_rise = xtal_q & ~xtal_qq;
  assign adv       = (mode_q == MD_TEST) ? xtal_rise : (mode_q != MD_OFF);
  assign at_wrap   = (32'(phase_q) == cycle_len(mode_q) - 1);

  always_comb begin
    if (restart)      phase_nxt = '0;
    else if (!adv)    phase_nxt = phase_q;
    else if (at_wrap) phase_nxt = '0;
    else              phase_nxt = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      xtal_q  <= 1'b0;
      xtal_qq <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      xtal_q  <= xtal_in;
      xtal_qq <= xtal_q;
    end
  end

endmodule

// File: rtl/sysclk_div_lanes.sv
module sysclk_div_lanes
  import sysclk_div_pkg::*;
#(
  parameter int unsigned PH_W = PHASE_W,
  parameter int unsigned LN   = LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ratio_mode_e     mode_q,
  input  ratio_mode_e     mode_nxt,
  input  logic [PH_W-1:0] phase_nxt,
  input  logic            usb_on_nxt,
  input  logic            xtal_in,
  input  logic            usb_in,
  output logic [LN-1:0]   lane_o,
  output logic            ref_o,
  output logic            usb_o
);

  logic [LN-1:0] lvl_q;
  logic          mid_lag;

  for (genvar g = 0; g < LN; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lvl_q[g] <= 1'b0;
      else if (mode_nxt == MD_OFF) lvl_q[g] <= 1'b0;
      else lvl_q[g] <= lane_level(32'(phase_nxt), lane_div(mode_nxt, g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o <= 1'b0;
      usb_o <= 1'b0;
    end else begin
      ref_o <= (mode_nxt != MD_OFF) & xtal_in;
      case (mode_nxt)
        MD_OFF:  usb_o <= 1'b0;
        MD_TEST: usb_o <= lane_level(32'(phase_nxt), 2);
        default: usb_o <= usb_on_nxt & usb_in;
      endcase
    end
  end

  // falling-edge copy stretches the odd divide to half a cycle past the next edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mid_lag <= 1'b0;
    else        mid_lag <= lvl_q[L_MID];
  end

  always_comb begin
    lane_o        = lvl_q;
    lane_o[L_MID] = lvl_q[L_MID] | ((mode_q == MD_SLOW) & mid_lag);
  end

endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
  import sysclk_div_pkg::*;
#(
  parameter int unsigned PH_W = PHASE_W,
  parameter int unsigned LN   = LANES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_freq,
  input  logic [1:0] sel_mode,
  input  logic       xtal_in,
  input  logic       usb_in,
  output logic       cpu_clk,
  output logic       cpu_half_clk,
  output logic       mid_clk,
  output logic       pci_clk,
  output logic       apic_clk,
  output logic       ref_clk,
  output logic       usb_clk,
  output logic       core_oe,
  output logic       usb_oe
);

  ratio_mode_e     mode_q, mode_nxt;
  logic            usb_on_q, usb_on_nxt;
  logic            restart_evt, adv_evt;
  logic [PH_W-1:0] phase_nxt;
  logic [LN-1:0]   lanes;

  sysclk_div_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_freq   (sel_freq),
    .sel_mode   (sel_mode),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .usb_on_q   (usb_on_q),
    .usb_on_nxt (usb_on_nxt),
    .restart    (restart_evt)
  );

  sysclk_div_phase #(.PH_W(PH_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart_evt),
    .mode_q    (mode_q),
    .xtal_in   (xtal_in),
    .phase_nxt (phase_nxt),
    .adv       (adv_evt)
  );

  sysclk_div_lanes #(.PH_W(PH_W), .LN(LN)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .phase_nxt  (phase_nxt),
    .usb_on_nxt (usb_on_nxt),
    .xtal_in    (xtal_in),
    .usb_in     (usb_in),
    .lane_o     (lanes),
    .ref_o      (ref_clk),
    .usb_o      (usb_clk)
  );

  assign cpu_clk      = lanes[L_CPU];
  assign cpu_half_clk = lanes[L_HALF];
  assign mid_clk      = lanes[L_MID];
  assign pci_clk      = lanes[L_PCI];
  assign apic_clk     = lanes[L_APIC];
  assign core_oe      = (mode_q != MD_OFF);
  assign usb_oe       = usb_on_q;

endmodule

// File: rtl/sysclk_div_chk.sv
module sysclk_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_freq,
  input logic [1:0] sel_mode,
  input logic       cpu_clk,
  input logic       cpu_half_clk,
  input logic       mid_clk,
  input logic       pci_clk,
  input logic       apic_clk,
  input logic       ref_clk,
  input logic       usb_clk,
  input logic       core_oe,
  input logic       usb_oe,
  input logic       restart_evt,
  input logic       adv_evt
);

  p_sel_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (core_oe == ($past({sel_freq, sel_mode}) != 3'b000)));

  p_restart_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && ({sel_freq, sel_mode} != 3'b000))
      |=> (cpu_clk && cpu_half_clk && mid_clk && pci_clk && apic_clk));

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_oe |-> !(cpu_clk | cpu_half_clk | mid_clk | pci_clk | apic_clk | ref_clk | usb_clk | usb_oe));

  p_cpu_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !restart_evt) |=> (cpu_clk != $past(cpu_clk)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !restart_evt) |=> ($stable(cpu_clk) && $stable(pci_clk) && $stable(apic_clk)));

  p_usb_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (usb_oe == (($past({sel_freq, sel_mode}) != 3'b000) && ($past(sel_mode) != 2'b01))));

  p_pci_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk) |-> cpu_clk);

  p_apic_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(apic_clk) |-> (pci_clk && cpu_half_clk));

endmodule

bind sysclk_ratio_div sysclk_div_chk i_chk (.*);

// File: tb/test_sysclk_ratio_div.sv
`timescale 1ns/100ps
module test_sysclk_ratio_div;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, sel_freq, xtal_in, usb_in;
  logic [1:0] sel_mode;
  logic cpu_clk, cpu_half_clk, mid_clk, pci_clk, apic_clk, ref_clk, usb_clk, core_oe, usb_oe;

  sysclk_ratio_div i_sysclk_ratio_div (
    .clk(clk), .rst_n(rst_n), .sel_freq(sel_freq), .sel_mode(sel_mode),
    .xtal_in(xtal_in), .usb_in(usb_in),
    .cpu_clk(cpu_clk), .cpu_half_clk(cpu_half_clk), .mid_clk(mid_clk),
    .pci_clk(pci_clk), .apic_clk(apic_clk), .ref_clk(ref_clk),
    .usb_clk(usb_clk), .core_oe(core_oe), .usb_oe(usb_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [2:0]  m_sel = 3'b000;
  int unsigned k = 0;
  logic        xq = 1'b0, xqq = 1'b0;
  logic        s_xtal = 1'b0, s_usb = 1'b0;
  logic        prev_pci = 1'b0, prev_apic = 1'b0;

  task automatic check1(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit is_fast(input logic [2:0] s); return s[2]; endfunction
  function automatic bit is_test(input logic [2:0] s); return s == 3'b010; endfunction

  function automatic string set_tag(input logic [2:0] s);
    if (s == 3'b000) return "R3";
    if (is_test(s))  return "R7";
    if (is_fast(s))  return "R4";
    return "R5";
  endfunction

  // expected level: high while twice the offset into the period is below the period
  function automatic logic want_lane(input int lane, input logic [2:0] s, input int unsigned kk, input bit neg);
    int unsigned per;
    if (s == 3'b000) return 1'b0;
    if (is_fast(s) || is_test(s)) begin
      case (lane) 0: per = 2; 1: per = 4; 2: per = 4; 3: per = 8; default: per = 16; endcase
    end else begin
      if (lane == 2) return ((2 * kk + (neg ? 1 : 0)) % 6) < 3;
      case (lane) 0: per = 2; 1: per = 4; 3: per = 6; default: per = 12; endcase
    end
    return 2 * (kk % per) < per;
  endfunction

  task automatic compare(input bit neg);
    logic [4:0] got;
    string t;
    logic eu;
    got = {apic_clk, pci_clk, mid_clk, cpu_half_clk, cpu_clk};
    t = set_tag(m_sel);
    for (int i = 0; i < 5; i++)
      check1((i == 2 && t == "R5") ? "R6" : t, $sformatf("lane%0d k=%0d neg=%0d", i, k, neg),
             got[i], want_lane(i, m_sel, k, neg));
    check1((m_sel == 0) ? "R3" : "R8", "ref_clk", ref_clk, (m_sel != 0) & s_xtal);
    if (m_sel == 0)              eu = 1'b0;
    else if (is_test(m_sel))     eu = (k % 2) == 0;
    else if (m_sel[1:0] == 2'b01) eu = 1'b0;
    else                         eu = s_usb;
    check1(is_test(m_sel) ? "R7" : "R9", "usb_clk", usb_clk, eu);
    check1("R2", "core_oe", core_oe, m_sel != 0);
    check1("R9", "usb_oe", usb_oe, (m_sel != 0) && (m_sel[1:0] != 2'b01));
    if (!neg) begin
      if (k == 0 && m_sel != 0)
        check1("R2", "all lanes high after restart", &got, 1'b1);
      if (pci_clk && !prev_pci)   check1("R10", "cpu high at pci rise", cpu_clk, 1'b1);
      if (apic_clk && !prev_apic) check1("R10", "pci high at apic rise", pci_clk & cpu_half_clk, 1'b1);
      prev_pci  = pci_clk;
      prev_apic = apic_clk;
    end
  endtask

  task automatic tick();
    logic rise;
    @(posedge clk);
    rise = xq & ~xqq;
    xqq  = xq;
    xq   = xtal_in;
    s_xtal = xtal_in;
    s_usb  = usb_in;
    if ({sel_freq, sel_mode} != m_sel) begin
      m_sel = {sel_freq, sel_mode};
      k = 0;
    end else if (m_sel != 0) begin
      if (is_test(m_sel)) begin
        if (rise) k++;
      end else k++;
    end
    #0.5 compare(1'b0);
    @(negedge clk);
    #0.5 compare(1'b1);
  endtask

  task automatic set_sel(input logic [2:0] s);
    {sel_freq, sel_mode} = s;
  endtask

  task automatic run_rand(input int n, input logic [2:0] s);
    set_sel(s);
    for (int i = 0; i < n; i++) begin
      xtal_in = $urandom % 2;
      usb_in  = $urandom % 2;
      tick();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; set_sel(3'b000); xtal_in = 1'b0; usb_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check1("R1", "cpu_clk", cpu_clk, 1'b0);
    check1("R1", "cpu_half_clk", cpu_half_clk, 1'b0);
    check1("R1", "mid_clk", mid_clk, 1'b0);
    check1("R1", "pci_clk", pci_clk, 1'b0);
    check1("R1", "apic_clk", apic_clk, 1'b0);
    check1("R1", "ref_clk", ref_clk, 1'b0);
    check1("R1", "usb_clk", usb_clk, 1'b0);
    check1("R1", "core_oe", core_oe, 1'b0);
    check1("R1", "usb_oe", usb_oe, 1'b0);
    @(negedge clk); #0.5 rst_n = 1'b1;

    run_rand(8, 3'b000);   // R3 floating
    run_rand(40, 3'b111);  // R4 fast set
    run_rand(40, 3'b011);  // R5, R6 slow set
    run_rand(20, 3'b001);  // R9 usb floated, slow
    run_rand(20, 3'b101);  // R9 usb floated, fast
    run_rand(20, 3'b100);  // R4 fast with usb
    // R7 regular test clock, period 4 clk cycles
    set_sel(3'b010);
    for (int i = 0; i < 80; i++) begin
      xtal_in = (i / 2) % 2;
      usb_in  = $urandom % 2;
      tick();
    end
    run_rand(100, 3'b010); // R7 irregular test clock
    // R2 directed mid-period switches
    for (int r = 0; r < 3; r++) begin
      run_rand(5 + r, 3'b111);
      run_rand(7 + r, 3'b011);
      run_rand(3, 3'b010);
      run_rand(1, 3'b000);
    end
    // random mix of selects
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) set_sel(3'($urandom % 8));
      xtal_in = $urandom % 2;
      usb_in  = $urandom % 2;
      tick();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule